// File: doc/BRIEF.md
# Board Reset and Control Manager

This block sits on each trigger processing card and turns several reset sources into separate, stretched reset strobes. There are four of them. The first is a full card initialisation that acts like a power cycle and ends with a configuration reload request. The second is a soft reset that idles the processing state machines and flushes the data buffers but leaves the control register alone. The third is a backplane system reset. The fourth is a message-bus abort that only drops the transfer in flight. A backplane system-fail indication never resets the card. It is synchronised and passed on as an interrupt line that asks the administrator node to initialise.

The full initialisation can start from three sources: power-up, a debounced front-panel pushbutton, or a two-step register command. The card holds initialisation for as long as any supply-good input is low, and for a fixed stable window after all of them come up. Because of this, the order in which the supplies come up does not matter. While initialisation is active, the block samples the geographic slot pins and freezes them into a register base address. A read-only register returns the firmware version.

Top module: `card_rst_ctrl`

## Requirements
- R1: `init_rst` is high out of reset and stays high while any `pwr_good` bit is low. Once all bits are high, it falls on the clock edge PWR_STABLE_CYC+RST_HOLD+2 cycles after the last bit rises. A supply dropping later restarts this sequence.
- R2: A trigger of one cycle produces a strobe exactly RST_HOLD cycles long. A trigger held L cycles (after the 2-flop synchroniser for the backplane inputs) produces a strobe L+RST_HOLD-1 cycles long.
- R3: Writing 0xA5 to the command register (address 1) arms the unit. Writing 0x5A to address 1 starts a full initialisation only if the previous command write was 0xA5. Any other command write disarms the unit, and an execute write without arming has no effect.
- R4: A full initialisation sets the control register (address 0) to CTRL_DEFAULT. It also raises `cfg_reload` for exactly one cycle: the first cycle after `init_rst` falls.
- R5: Writing 0x3C to address 1 raises `soft_rst` for RST_HOLD cycles. It leaves the control register unchanged and does not raise `init_rst`.
- R6: The pushbutton is synchronised and debounced. A level held for fewer than DEB_CYC cycles is ignored, and each accepted press starts exactly one full initialisation.
- R7: A high level on `mbus_rst_req` raises only `mbus_abort`. No other strobe is raised.
- R8: A low level on `sysreset_n` raises `sys_rst`.
- R9: `irq_init_req` follows the inverse of `sysfail_n` with two cycles of latency, and raises no reset strobe.
- R10: `base_addr` equals the slot pins shifted left by BASE_SHIFT. The slot pins are sampled while `init_rst` is high and held otherwise.
- R11: Address 2 reads FW_VERSION, and writes to address 2 have no effect. Address 3 reads the latched slot number.
- R12: Register writes are ignored while `init_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | N_SUPPLY | Supply-good indications, asynchronous |
| btn_raw | input | 1 | Front-panel pushbutton, high when pressed, asynchronous |
| sysreset_n | input | 1 | Backplane system reset, active low, asynchronous |
| sysfail_n | input | 1 | Backplane system-fail, active low, asynchronous |
| mbus_rst_req | input | 1 | Message-bus reset request, asynchronous |
| slot_addr | input | SLOT_W | Geographic slot pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| init_rst | output | 1 | Full card initialisation strobe |
| cfg_reload | output | 1 | Configuration reload request, one cycle |
| soft_rst | output | 1 | Soft card reset strobe |
| sys_rst | output | 1 | Backplane system reset strobe |
| mbus_abort | output | 1 | Message-bus transfer abort strobe |
| irq_init_req | output | 1 | Initialisation-request interrupt |
| base_addr | output | SLOT_W+BASE_SHIFT | Register base address |

## Verification
The properties assume two things. First, the register port is driven synchronously. Second, `wr_en` is the only source of control register changes apart from initialisation. The bench therefore changes every register-port input on the falling edge and holds each write for exactly one cycle. The asynchronous inputs (supplies, button, backplane lines, slot pins) are also changed on falling edges, and each is held for several cycles so that the synchroniser latency is deterministic. The slot pins are only changed well away from an initialisation window, so the latched value is unambiguous.

// File: rtl/cr_pkg.sv
// Shared constants for the card reset manager.
// Assumes an 8-bit register port with four word addresses.
package cr_pkg;
    localparam int DATA_W = 8;
    typedef logic [DATA_W-1:0] cr_word_t;

    // register selects
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_VER  = 2'd2;
    localparam logic [1:0] SEL_SLOT = 2'd3;

    // command codes written to SEL_CMD
    localparam cr_word_t CODE_ARM  = 8'hA5;
    localparam cr_word_t CODE_EXEC = 8'h5A;
    localparam cr_word_t CODE_SOFT = 8'h3C;

    // strobe indices
    localparam int N_STROBE = 4;
    localparam int ST_INIT  = 0;
    localparam int ST_SOFT  = 1;
    localparam int ST_SYS   = 2;
    localparam int ST_MBUS  = 3;
endpackage

// File: rtl/cr_sync.sv
// Two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module cr_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // two register stages towards the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/cr_debounce.sv
// Debounces a synchronised pushbutton and emits one pulse per accepted press.
// Assumes DEB_CYC >= 2 and that btn_s is already synchronised.
module cr_debounce #(
    parameter int DEB_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_s,
    output logic press_pulse
);
    localparam int            CW   = $clog2(DEB_CYC);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    logic          stable_q;
    logic [CW-1:0] cnt_q;

    // accept a new level only after it has persisted DEB_CYC cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q    <= 1'b0;
            cnt_q       <= '0;
            press_pulse <= 1'b0;
        end else begin
            press_pulse <= 1'b0;
            if (btn_s != stable_q) begin
                if (cnt_q == LAST) begin
                    stable_q    <= btn_s;
                    cnt_q       <= '0;
                    press_pulse <= btn_s;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/cr_stretch.sv
// Stretches a trigger level into a strobe that lasts HOLD cycles past the
// last trigger cycle. Output decoded from a single counter register.
// Assumes HOLD >= 1.
module cr_stretch #(
    parameter int   HOLD   = 16,
    parameter logic RST_ON = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic strobe
);
    localparam int            CW  = $clog2(HOLD + 1);
    localparam logic [CW-1:0] TOP = CW'(HOLD);

    logic [CW-1:0] cnt_q;

    // reload on trigger, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= RST_ON ? TOP : '0;
        else if (trig)        cnt_q <= TOP;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign strobe = (cnt_q != '0);
endmodule

// File: rtl/cr_power_gate.sv
// Reports power-on complete once every supply-good input has been high
// without interruption for STABLE_CYC cycles; any drop restarts the wait.
// Assumes supply-good inputs are asynchronous.
module cr_power_gate #(
    parameter int N_SUPPLY   = 3,
    parameter int STABLE_CYC = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SUPPLY-1:0] pwr_good,
    output logic                por_done
);
    localparam int            CW  = $clog2(STABLE_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(STABLE_CYC);

    logic [N_SUPPLY-1:0] good_s;
    logic [CW-1:0]       cnt_q;

    cr_sync #(.W(N_SUPPLY), .RST_VAL('0)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pwr_good),
        .q_sync  (good_s)
    );

    // saturating stability counter, cleared by any missing supply
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!(&good_s))   cnt_q <= '0;
        else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end

    assign por_done = (cnt_q == LIM);
endmodule

// File: rtl/card_rst_ctrl.sv
// Card reset and control manager: merges power-up, pushbutton and register
// commands into a full initialisation, and produces soft, system and
// message-bus strobes plus a system-fail interrupt, slot base address and
// version register. Assumes a synchronous register port.
module card_rst_ctrl #(
    parameter int                    N_SUPPLY     = 3,
    parameter int                    PWR_STABLE_CYC = 1024,
    parameter int                    DEB_CYC      = 50000,
    parameter int                    RST_HOLD     = 16,
    parameter int                    SLOT_W       = 5,
    parameter int                    BASE_SHIFT   = 19,
    parameter logic [7:0]            FW_VERSION   = 8'h23,
    parameter logic [7:0]            CTRL_DEFAULT = 8'h01,
    localparam int                   BASE_W       = SLOT_W + BASE_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SUPPLY-1:0] pwr_good,
    input  logic                btn_raw,
    input  logic                sysreset_n,
    input  logic                sysfail_n,
    input  logic                mbus_rst_req,
    input  logic [SLOT_W-1:0]   slot_addr,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [1:0]          rd_addr,
    output logic [7:0]          rd_data,
    output logic                init_rst,
    output logic                cfg_reload,
    output logic                soft_rst,
    output logic                sys_rst,
    output logic                mbus_abort,
    output logic                irq_init_req,
    output logic [BASE_W-1:0]   base_addr
);
    import cr_pkg::*;

    localparam logic [N_STROBE-1:0] ON_AT_RESET = N_STROBE'(1) << ST_INIT;

    logic                por_done;
    logic                btn_s, press_pulse;
    logic [2:0]          bp_s;
    logic [SLOT_W-1:0]   slot_s, slot_q;
    logic [N_STROBE-1:0] trig, strobe;
    cr_word_t            ctrl_q;
    logic                armed_q, init_d;
    logic                cmd_wr, exec_cmd, soft_cmd;

    cr_power_gate #(.N_SUPPLY(N_SUPPLY), .STABLE_CYC(PWR_STABLE_CYC)) u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .por_done (por_done)
    );

    cr_sync #(.W(1), .RST_VAL(1'b0)) u_btn_sync (
        .clk (clk), .rst_n (rst_n), .d_async (btn_raw), .q_sync (btn_s)
    );

    cr_debounce #(.DEB_CYC(DEB_CYC)) u_btn (
        .clk (clk), .rst_n (rst_n), .btn_s (btn_s), .press_pulse (press_pulse)
    );

    // bit2 sysfail_n, bit1 sysreset_n, bit0 mbus request
    cr_sync #(.W(3), .RST_VAL(3'b110)) u_bp_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sysfail_n, sysreset_n, mbus_rst_req}),
        .q_sync  (bp_s)
    );

    cr_sync #(.W(SLOT_W), .RST_VAL('0)) u_slot_sync (
        .clk (clk), .rst_n (rst_n), .d_async (slot_addr), .q_sync (slot_s)
    );

    // command decode; writes blocked during initialisation
    assign cmd_wr   = wr_en && !init_rst && (wr_addr == SEL_CMD);
    assign exec_cmd = cmd_wr && armed_q && (wr_data == CODE_EXEC);
    assign soft_cmd = cmd_wr && (wr_data == CODE_SOFT);

    // trigger sources for each strobe
    always_comb begin
        trig           = '0;
        trig[ST_INIT]  = !por_done || press_pulse || exec_cmd;
        trig[ST_SOFT]  = soft_cmd;
        trig[ST_SYS]   = !bp_s[1];
        trig[ST_MBUS]  = bp_s[0];
    end

    generate
        for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
            cr_stretch #(.HOLD(RST_HOLD), .RST_ON(ON_AT_RESET[g])) u_st (
                .clk    (clk),
                .rst_n  (rst_n),
                .trig   (trig[g]),
                .strobe (strobe[g])
            );
        end
    endgenerate

    assign init_rst   = strobe[ST_INIT];
    assign soft_rst   = strobe[ST_SOFT];
    assign sys_rst    = strobe[ST_SYS];
    assign mbus_abort = strobe[ST_MBUS];

    // control register: defaulted by initialisation only
    always_ff @(posedge clk) begin
        if (!rst_n || init_rst)
            ctrl_q <= CTRL_DEFAULT;
        else if (wr_en && wr_addr == SEL_CTRL)
            ctrl_q <= wr_data;
    end

    // unlock state: set by an arm write, consumed by any command write
    always_ff @(posedge clk) begin
        if (!rst_n || init_rst) armed_q <= 1'b0;
        else if (cmd_wr)        armed_q <= (wr_data == CODE_ARM);
    end

    // slot pins tracked during initialisation, frozen afterwards
    always_ff @(posedge clk) begin
        if (!rst_n)        slot_q <= '0;
        else if (init_rst) slot_q <= slot_s;
    end

    // delayed copy of init strobe for the reload pulse
    always_ff @(posedge clk) begin
        if (!rst_n) init_d <= 1'b1;
        else        init_d <= init_rst;
    end

    assign cfg_reload   = init_d && !init_rst;
    assign irq_init_req = !bp_s[2];
    assign base_addr    = {slot_q, {BASE_SHIFT{1'b0}}};

    // register read mux
    always_comb begin
        case (rd_addr)
            SEL_CTRL: rd_data = ctrl_q;
            SEL_VER:  rd_data = FW_VERSION;
            SEL_SLOT: rd_data = DATA_W'(slot_q);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/card_rst_ctrl_chk.sv
// Property checker for card_rst_ctrl, attached by bind.
// Assumes the register port changes only through synchronous writes.
module card_rst_ctrl_chk #(
    parameter logic [7:0] CTRL_DEFAULT = 8'h01,
    parameter int         BASE_W       = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_done,
    input logic              init_rst,
    input logic              soft_rst,
    input logic              cfg_reload,
    input logic              wr_en,
    input logic [7:0]        ctrl_q,
    input logic [BASE_W-1:0] base_addr
);
    // R1: an incomplete power-up keeps the card in initialisation
    assert_por_holds_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !por_done |=> init_rst);

    // R4: initialisation returns the control register to its default
    assert_init_defaults_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_rst |=> (ctrl_q == CTRL_DEFAULT));

    // R4: reload request lasts one cycle
    assert_reload_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reload |=> !cfg_reload);

    // R5: soft reset alone does not disturb the control register
    assert_soft_keeps_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !init_rst && !wr_en) |=> $stable(ctrl_q));

    // R10: base address frozen outside initialisation
    assert_base_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !init_rst |=> $stable(base_addr));
endmodule

bind card_rst_ctrl card_rst_ctrl_chk #(
    .CTRL_DEFAULT (CTRL_DEFAULT),
    .BASE_W       (BASE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_done   (por_done),
    .init_rst   (init_rst),
    .soft_rst   (soft_rst),
    .cfg_reload (cfg_reload),
    .wr_en      (wr_en),
    .ctrl_q     (ctrl_q),
    .base_addr  (base_addr)
);

// File: tb/card_rst_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue the strobe events each stimulus should
// cause; a monitor measures every strobe pulse and compares in order.
module card_rst_ctrl_tb;
    localparam int P     = 20;
    localparam int HOLD  = 16;
    localparam int DEB   = 8;
    localparam int SH    = 19;
    localparam logic [7:0] VER = 8'h23;
    localparam logic [7:0] DEF = 8'h01;
    localparam int K_INIT = 0, K_RELOAD = 1, K_SOFT = 2, K_SYS = 3, K_MBUS = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  pwr_good = '0;
    logic        btn_raw = 0, sysreset_n = 1, sysfail_n = 1, mbus_rst_req = 0;
    logic [4:0]  slot_addr = 5'd9;
    logic        wr_en = 0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [7:0]  wr_data = '0, rd_data;
    logic        init_rst, cfg_reload, soft_rst, sys_rst, mbus_abort, irq_init_req;
    logic [23:0] base_addr;

    card_rst_ctrl #(.N_SUPPLY(3), .PWR_STABLE_CYC(P), .DEB_CYC(DEB),
                    .RST_HOLD(HOLD), .SLOT_W(5), .BASE_SHIFT(SH),
                    .FW_VERSION(VER), .CTRL_DEFAULT(DEF)) u_dut (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    typedef struct { int kind; int len; } ev_t;
    ev_t exp_q[$];
    bit  mon_en = 0;
    int  run_len[5];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic expect_ev(input int kind, input int len);
        ev_t e; e.kind = kind; e.len = len; exp_q.push_back(e);
    endtask

    // compare a finished pulse against the head of the queue
    task automatic seen(input int kind, input int len);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk(0, "R2", $sformatf("unexpected strobe kind %0d", kind), len, 0);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == kind, "R2", "strobe kind", kind, e.kind);
            if (e.len != 0) chk(e.len == len, "R2", "strobe length", len, e.len);
        end
    endtask

    // monitor: measure each strobe's high time, report on its fall
    always @(negedge clk) begin
        if (mon_en) begin
            logic [4:0] v;
            v = {mbus_abort, sys_rst, soft_rst, cfg_reload, init_rst};
            for (int k = 0; k < 5; k++) begin
                if (v[k]) run_len[k]++;
                else if (run_len[k] > 0) begin
                    seen(k, run_len[k]);
                    run_len[k] = 0;
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 400) begin @(negedge clk); t++; end
        chk(exp_q.size() == 0, req, "expected events left", exp_q.size(), 0);
        wait_cyc(30);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_addr = a; #1 d = rd_data;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        logic [7:0] r;
        for (int k = 0; k < 5; k++) run_len[k] = 0;
        wait_cyc(5);
        chk(init_rst == 1, "R1", "init in reset", init_rst, 1);
        chk(soft_rst == 0 && sys_rst == 0 && mbus_abort == 0, "R2", "other strobes idle", soft_rst, 0);
        @(negedge clk); rst_n = 1;
        // supplies rise in an arbitrary order
        @(negedge clk); pwr_good[2] = 1;
        wait_cyc(P + 10);
        chk(init_rst == 1, "R1", "init held with one supply", init_rst, 1);
        @(negedge clk); pwr_good[0] = 1;
        wait_cyc(P + 10);
        chk(init_rst == 1, "R1", "init held with two supplies", init_rst, 1);
        @(negedge clk); pwr_good[1] = 1;
        wait_cyc(P + HOLD + 1);
        chk(init_rst == 1, "R1", "init still high at window end", init_rst, 1);
        @(negedge clk);
        chk(init_rst == 0, "R1", "init released", init_rst, 0);
        chk(cfg_reload == 1, "R4", "reload after power-up", cfg_reload, 1);
        @(negedge clk);
        chk(cfg_reload == 0, "R4", "reload one cycle", cfg_reload, 0);

        rd(2'd2, r); chk(r == VER, "R11", "version", r, VER);
        rd(2'd0, r); chk(r == DEF, "R4", "ctrl default", r, DEF);
        chk(base_addr == (24'd9 << SH), "R10", "base from slot", base_addr, 24'd9 << SH);
        rd(2'd3, r); chk(r == 8'd9, "R11", "slot readback", r, 9);
        mon_en = 1;

        // R5 soft reset keeps ctrl
        wr(2'd0, 8'h5C);
        expect_ev(K_SOFT, HOLD);
        wr(2'd1, 8'h3C);
        drain("R5");
        rd(2'd0, r); chk(r == 8'h5C, "R5", "ctrl kept by soft reset", r, 8'h5C);

        // R3 execute without arm, and arm cancelled by another write
        wr(2'd1, 8'h5A);
        wr(2'd1, 8'hA5); wr(2'd1, 8'h00); wr(2'd1, 8'h5A);
        drain("R3");
        rd(2'd0, r); chk(r == 8'h5C, "R3", "no init without unlock", r, 8'h5C);

        // R11 version is read-only
        wr(2'd2, 8'hFF);
        rd(2'd2, r); chk(r == VER, "R11", "version after write", r, VER);

        // R10 slot change ignored outside initialisation
        slot_addr = 5'd17;
        wait_cyc(10);
        chk(base_addr == (24'd9 << SH), "R10", "base frozen", base_addr, 24'd9 << SH);

        // R3/R12 unlocked init, write during init ignored
        expect_ev(K_INIT, HOLD); expect_ev(K_RELOAD, 1);
        wr(2'd1, 8'hA5);
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'h77);
        drain("R3");
        rd(2'd0, r); chk(r == DEF, "R12", "write during init ignored", r, DEF);
        chk(base_addr == (24'd17 << SH), "R10", "base relatched", base_addr, 24'd17 << SH);

        // R7 message-bus reset only aborts
        expect_ev(K_MBUS, 3 + HOLD - 1);
        @(negedge clk); mbus_rst_req = 1; wait_cyc(3); mbus_rst_req = 0;
        drain("R7");

        // R8 backplane system reset
        expect_ev(K_SYS, 5 + HOLD - 1);
        @(negedge clk); sysreset_n = 0; wait_cyc(5); sysreset_n = 1;
        drain("R8");

        // R9 system-fail becomes interrupt only
        @(negedge clk); sysfail_n = 0;
        @(negedge clk); chk(irq_init_req == 0, "R9", "irq latency 1", irq_init_req, 0);
        @(negedge clk); chk(irq_init_req == 1, "R9", "irq raised", irq_init_req, 1);
        wait_cyc(10); sysfail_n = 1;
        wait_cyc(3);
        chk(irq_init_req == 0, "R9", "irq cleared", irq_init_req, 0);
        drain("R9");

        // R6 short glitch ignored, bouncing press gives one init
        @(negedge clk); btn_raw = 1; wait_cyc(3); btn_raw = 0;
        drain("R6");
        expect_ev(K_INIT, HOLD); expect_ev(K_RELOAD, 1);
        @(negedge clk); btn_raw = 1; @(negedge clk); btn_raw = 0;
        @(negedge clk); btn_raw = 1; @(negedge clk); btn_raw = 0;
        @(negedge clk); btn_raw = 1; wait_cyc(40);
        btn_raw = 0; @(negedge clk); btn_raw = 1; @(negedge clk); btn_raw = 0;
        wait_cyc(40);
        drain("R6");

        // R1 supply dropout restarts initialisation
        wr(2'd0, 8'h33);
        expect_ev(K_INIT, 0); expect_ev(K_RELOAD, 1);
        @(negedge clk); pwr_good[1] = 0; wait_cyc(4); pwr_good[1] = 1;
        drain("R1");
        rd(2'd0, r); chk(r == DEF, "R1", "ctrl default after dropout", r, DEF);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule